// File: doc/BRIEF.md
# Expansion Bus Slave Address Decoder

This block is the address front end of a slave adapter on a 16-bit expansion bus. The bus drives seven upper memory address lines (address bits 23 to 17) unlatched: they are valid only around the address-latch-enable strobe. The lower twenty system address lines are already held by the bus for the whole command phase. The decoder keeps its own copy of the upper lines and joins them with the lower lines to form a 24-bit memory address. It then tests that address against a set of memory windows, or tests the lower address lines against an I/O port window.

In a normal cycle the kept copy of the upper lines is used. During DMA or bus-master transfers no latch-enable strobe frames the address, so a DMA-active input switches the decoder to the live upper lines. These lines are valid a clock or more before the command strobe in such transfers.

The I/O window can be compared on sixteen address bits. It can also be compared on ten bits only, so that it appears again every 1 KB of I/O space. A hit on a window marked 16-bit capable pulls the matching active-low memory-16 or I/O-16 reply low. Byte-lane enables are formed from address bit 0 and the active-low high-byte-enable. All outputs are registered and follow the sampled inputs by one clock.

Top module: `bus_slave_decode`

## Requirements
- R1: While `rst` is high, and on the first clock after it, the outputs read `hit_mem`=0, `hit_io`=0, `mem16_n`=1, `io16_n`=1, `lane_lo`=0, `lane_hi`=0. The held upper address is cleared to 0.
- R2: While `ale` is high, the held upper address follows `la_in` and the live value is used for decoding. Once `ale` is low and `dma_act` is low, the value last sampled with `ale` high is used, and later changes on `la_in` have no effect on any output.
- R3: With `dma_act` high, the live `la_in` is used for memory decode, whatever `ale` did.
- R4: The memory address is {upper lines, `sa_in[16:0]`}. `hit_mem` is 1 one clock after a sampled `mem_cmd`=1 whose address satisfies (addr & MASK) == (BASE & MASK) for some window. The defaults are window 0 = base 0x0C8000, mask 0xFFC000, and window 1 = base 0xE00000, mask 0xF00000.
- R5: `mem16_n` is 0 exactly when the registered memory hit came from a window flagged 16-bit. By default only window 1 is flagged.
- R6: In full I/O mode (`io_short`=0), `hit_io` is 1 one clock after a sampled `io_cmd`=1 with (`sa_in[15:0]` & 0xFFF0) == 0x0300. `sa_in[19:16]` is ignored.
- R7: In short I/O mode (`io_short`=1), only `sa_in[9:0]` is compared, against 0x300 under mask 0x3F0. The window therefore repeats every 0x400.
- R8: `io16_n` is 0 exactly when `hit_io` is 1, because the default I/O window is flagged 16-bit.
- R9: `lane_lo` equals NOT `sa_in[0]` and `lane_hi` equals NOT `sbhe_n`. Both are registered with the hit and forced to 0 when neither hit is set.
- R10: With `mem_cmd` and `io_cmd` both low, every hit, 16-bit reply and lane output is inactive one clock later, even when the address matches a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock sampling all bus inputs |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address latch enable strobe |
| dma_act | input | 1 | DMA or bus-master transfer in progress |
| la_in | input | 7 | Unlatched upper address lines, bits 23..17 |
| sa_in | input | 20 | Latched system address lines, bits 19..0 |
| sbhe_n | input | 1 | Active-low high byte enable |
| mem_cmd | input | 1 | Memory read or write command active |
| io_cmd | input | 1 | I/O read or write command active |
| io_short | input | 1 | Selects the 10-bit aliased I/O decode |
| hit_mem | output | 1 | Memory window hit, registered |
| hit_io | output | 1 | I/O window hit, registered |
| mem16_n | output | 1 | Active-low 16-bit memory reply |
| io16_n | output | 1 | Active-low 16-bit I/O reply |
| lane_lo | output | 1 | Low byte lane enable |
| lane_hi | output | 1 | High byte lane enable |

## Verification
The hardest case to reach is a normal cycle in which the upper address lines change after `ale` falls. In that case the decode must still use the held value. The stimulus raises `ale` with an in-window upper address and lowers it. It then drives unrelated upper lines while the memory command is active. The same live/held contrast is repeated with `dma_act` toggled, so that both paths are seen to give different answers. I/O aliasing is swept by moving the address across several 1 KB blocks in both modes.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int LA_W   = 7;
  localparam int SA_W   = 20;
  localparam int MA_W   = 24;
  localparam int IO_W   = 16;
  localparam int IO10_W = 10;
  localparam int LO_W   = MA_W - LA_W;

  typedef struct packed {
    logic hit_mem;
    logic hit_io;
    logic mem16_n;
    logic io16_n;
    logic lane_lo;
    logic lane_hi;
  } dec_out_t;

  localparam dec_out_t DEC_IDLE = '{hit_mem: 1'b0, hit_io: 1'b0, mem16_n: 1'b1,
                                   io16_n: 1'b1, lane_lo: 1'b0, lane_hi: 1'b0};
endpackage

// File: rtl/la_capture.sv
module la_capture import bsd_pkg::*; #(
  parameter int W = LA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ale,
  input  logic         dma_act,
  input  logic [W-1:0] la_in,
  output logic [W-1:0] la_eff
);
  logic [W-1:0] la_hold;

  always_ff @(posedge clk) begin
    if (rst)      la_hold <= '0;
    else if (ale) la_hold <= la_in;
  end

  assign la_eff = (dma_act || ale) ? la_in : la_hold;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(la_hold)); // R2
endmodule

// File: rtl/mem_decode.sv
module mem_decode import bsd_pkg::*; #(
  parameter int                 NWIN  = 2,
  parameter int                 AW    = MA_W,
  parameter logic [NWIN*AW-1:0] BASES = {24'hE00000, 24'h0C8000},
  parameter logic [NWIN*AW-1:0] MASKS = {24'hF00000, 24'hFFC000},
  parameter logic [NWIN-1:0]    WIDE  = 2'b10
) (
  input  logic [AW-1:0] addr,
  input  logic          en,
  output logic          hit,
  output logic          wide
);
  logic [NWIN-1:0] win_hit;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam logic [AW-1:0] B = BASES[i*AW +: AW];
    localparam logic [AW-1:0] M = MASKS[i*AW +: AW];
    assign win_hit[i] = en && ((addr & M) == (B & M));
  end

  assign hit  = |win_hit;
  assign wide = |(win_hit & WIDE);
endmodule

// File: rtl/io_decode.sv
module io_decode import bsd_pkg::*; #(
  parameter logic [IO_W-1:0] BASE = 16'h0300,
  parameter logic [IO_W-1:0] MASK = 16'hFFF0
) (
  input  logic [IO_W-1:0] sa,
  input  logic            short_mode,
  input  logic            en,
  output logic            hit
);
  localparam logic [IO10_W-1:0] B10 = BASE[IO10_W-1:0];
  localparam logic [IO10_W-1:0] M10 = MASK[IO10_W-1:0];

  logic full_eq, short_eq;

  assign full_eq  = (sa & MASK) == (BASE & MASK);
  assign short_eq = (sa[IO10_W-1:0] & M10) == (B10 & M10);
  assign hit      = en && (short_mode ? short_eq : full_eq);
endmodule

// File: rtl/bus_slave_decode.sv
module bus_slave_decode import bsd_pkg::*; #(
  parameter int                   NWIN      = 2,
  parameter logic [NWIN*MA_W-1:0] MEM_BASES = {24'hE00000, 24'h0C8000},
  parameter logic [NWIN*MA_W-1:0] MEM_MASKS = {24'hF00000, 24'hFFC000},
  parameter logic [NWIN-1:0]      MEM_WIDE  = 2'b10,
  parameter logic [IO_W-1:0]      IO_BASE   = 16'h0300,
  parameter logic [IO_W-1:0]      IO_MASK   = 16'hFFF0,
  parameter logic                 IO_WIDE   = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ale,
  input  logic            dma_act,
  input  logic [LA_W-1:0] la_in,
  input  logic [SA_W-1:0] sa_in,
  input  logic            sbhe_n,
  input  logic            mem_cmd,
  input  logic            io_cmd,
  input  logic            io_short,
  output logic            hit_mem,
  output logic            hit_io,
  output logic            mem16_n,
  output logic            io16_n,
  output logic            lane_lo,
  output logic            lane_hi
);
  logic [LA_W-1:0] la_eff;
  logic [MA_W-1:0] mem_addr;
  logic            m_hit, m_wide, i_hit, any_hit;
  logic            unused_sa_top;
  dec_out_t        nxt, cur;

  la_capture #(.W(LA_W)) u_cap (
    .clk(clk), .rst(rst), .ale(ale), .dma_act(dma_act),
    .la_in(la_in), .la_eff(la_eff)
  );

  assign mem_addr      = {la_eff, sa_in[LO_W-1:0]};
  assign unused_sa_top = ^sa_in[SA_W-1:LO_W];

  mem_decode #(
    .NWIN(NWIN), .AW(MA_W), .BASES(MEM_BASES), .MASKS(MEM_MASKS), .WIDE(MEM_WIDE)
  ) u_mem (
    .addr(mem_addr), .en(mem_cmd), .hit(m_hit), .wide(m_wide)
  );

  io_decode #(.BASE(IO_BASE), .MASK(IO_MASK)) u_io (
    .sa(sa_in[IO_W-1:0]), .short_mode(io_short), .en(io_cmd), .hit(i_hit)
  );

  assign any_hit = m_hit || i_hit;

  always_comb begin
    nxt.hit_mem = m_hit;
    nxt.hit_io  = i_hit;
    nxt.mem16_n = !(m_hit && m_wide);
    nxt.io16_n  = !(i_hit && IO_WIDE);
    nxt.lane_lo = any_hit && !sa_in[0];
    nxt.lane_hi = any_hit && !sbhe_n;
  end

  always_ff @(posedge clk) begin
    if (rst) cur <= DEC_IDLE;
    else     cur <= nxt;
  end

  assign hit_mem = cur.hit_mem;
  assign hit_io  = cur.hit_io;
  assign mem16_n = cur.mem16_n;
  assign io16_n  = cur.io16_n;
  assign lane_lo = cur.lane_lo;
  assign lane_hi = cur.lane_hi;

  AST_MEM_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    hit_mem |-> $past(mem_cmd)); // R4
  AST_IO_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
    hit_io |-> $past(io_cmd)); // R6
  AST_M16_WITH_HIT: assert property (@(posedge clk) disable iff (rst)
    !mem16_n |-> hit_mem); // R5
  AST_IO16_WITH_HIT: assert property (@(posedge clk) disable iff (rst)
    !io16_n |-> hit_io); // R8
  AST_LANE_GATED: assert property (@(posedge clk) disable iff (rst)
    (lane_lo || lane_hi) |-> (hit_mem || hit_io)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!mem_cmd && !io_cmd) |=> (!hit_mem && !hit_io)); // R10
endmodule

// File: tb/sim_bus_slave_decode.sv
`timescale 1ns/1ps
module sim_bus_slave_decode;
  logic        clk = 1'b0;
  logic        rst = 1'b1, ale = 1'b0, dma_act = 1'b0, sbhe_n = 1'b1;
  logic        mem_cmd = 1'b0, io_cmd = 1'b0, io_short = 1'b0;
  logic [6:0]  la_in = '0;
  logic [19:0] sa_in = '0;
  logic        hit_mem, hit_io, mem16_n, io16_n, lane_lo, lane_hi;

  int    checks = 0, fails = 0, cyc = 0;
  string tag = "R1";
  logic [6:0] m_hold = '0;

  always #2.5 clk = ~clk;

  bus_slave_decode u0 (
    .clk(clk), .rst(rst), .ale(ale), .dma_act(dma_act), .la_in(la_in),
    .sa_in(sa_in), .sbhe_n(sbhe_n), .mem_cmd(mem_cmd), .io_cmd(io_cmd),
    .io_short(io_short), .hit_mem(hit_mem), .hit_io(hit_io),
    .mem16_n(mem16_n), .io16_n(io16_n), .lane_lo(lane_lo), .lane_hi(lane_hi)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
    end
  end

  task automatic chk(string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, nm, act, exp);
    end
  endtask

  // Reference model: evaluate expected outputs from the sampled inputs, then clock.
  task automatic step();
    logic [6:0]  la_use;
    logic [23:0] a;
    logic        mh, m16, ih, any;
    la_use = (dma_act || ale) ? la_in : m_hold;
    a      = {la_use, sa_in[16:0]};
    mh     = mem_cmd && (((a & 24'hFFC000) == 24'h0C8000) || ((a & 24'hF00000) == 24'hE00000));
    m16    = mem_cmd && ((a & 24'hF00000) == 24'hE00000);
    ih     = io_cmd && (io_short ? ((sa_in[9:0] & 10'h3F0) == 10'h300)
                                 : ((sa_in[15:0] & 16'hFFF0) == 16'h0300));
    any    = mh || ih;
    if (rst) begin
      mh = 0; m16 = 0; ih = 0; any = 0; m_hold = '0;
    end else if (ale) begin
      m_hold = la_in;
    end
    @(posedge clk);
    #1;
    chk("hit_mem", hit_mem, mh);
    chk("hit_io",  hit_io,  ih);
    chk("mem16_n", mem16_n, !m16);
    chk("io16_n",  io16_n,  !ih);
    chk("lane_lo", lane_lo, any && !sa_in[0]);
    chk("lane_hi", lane_hi, any && !sbhe_n);
  endtask

  initial begin
    @(negedge clk);
    tag = "R1"; step(); step();
    rst = 1'b0; step();

    // Normal cycle: capture upper lines, then disturb them while the command runs
    tag = "R2"; ale = 1; la_in = 7'h70; sa_in = 20'h12345; step();
    ale = 0; la_in = 7'h00; mem_cmd = 1; sbhe_n = 0; step();
    tag = "R5"; la_in = 7'h55; step();
    tag = "R9"; sa_in = 20'h12344; sbhe_n = 1; step();
    tag = "R4"; mem_cmd = 0; step();

    // 8-bit window hit then miss
    tag = "R4"; ale = 1; la_in = 7'h06; sa_in = 20'h08123; step();
    ale = 0; la_in = 7'h7F; mem_cmd = 1; step();
    tag = "R5"; sa_in = 20'h08122; sbhe_n = 0; step();
    tag = "R4"; sa_in = 20'h04123; step();
    mem_cmd = 0; step();

    // DMA uses live lines; held value (0x06) would miss here
    tag = "R3"; dma_act = 1; la_in = 7'h70; sa_in = 20'h00010; mem_cmd = 1; step();
    la_in = 7'h72; step();
    tag = "R2"; dma_act = 0; step();
    tag = "R3"; dma_act = 1; la_in = 7'h06; sa_in = 20'h0C000; step();
    mem_cmd = 0; dma_act = 0; step();

    // I/O full decode
    tag = "R6"; io_cmd = 1; sa_in = 20'h00305; sbhe_n = 1; step();
    tag = "R8"; sa_in = 20'hF0304; sbhe_n = 0; step();
    tag = "R6"; sa_in = 20'h00704; step();
    sa_in = 20'h00310; step();
    for (int i = 0; i < 8; i++) begin
      tag = "R6"; io_short = 0; sa_in = 20'((i << 10) | 12'h300 | i); step();
      tag = "R7"; io_short = 1; step();
    end
    tag = "R7"; sa_in = 20'h00B0F; step();
    sa_in = 20'h00710; step();
    io_cmd = 0; io_short = 0; step();

    // No command: matching addresses stay quiet
    tag = "R10"; ale = 1; la_in = 7'h70; sa_in = 20'h00300; step();
    ale = 0; step();
    io_short = 1; step();
    tag = "R10"; mem_cmd = 1; io_cmd = 0; step();
    mem_cmd = 0; step();

    tag = "R1"; rst = 1; mem_cmd = 1; step();
    rst = 0; mem_cmd = 0; step();

    summary();
    $finish;
  end
endmodule